// File: doc/BRIEF.md
# Burst-capable synchronous memory slave

This block is a word-addressed RAM that sits behind a Wishbone B3 slave port with registered feedback. It serves single classic cycles and both kinds of burst: bursts that repeat one address, and bursts whose address steps up by one word each beat. A stepping burst either runs linearly or stays inside an aligned window of 4, 8 or 16 words, folding back to the start of that window.

The first beat of any transfer is answered one cycle after the strobe. After that, as long as the master's cycle type promises another beat, the slave computes the following address itself and fetches its word early, so the remaining beats are acknowledged back to back. A master may pull its strobe, or its whole cycle, low between beats at any point, including right after the first beat. When it does, the early-fetched word and the predicted address are thrown away. The next strobe is then treated as a fresh request at whatever address the master drives.

Top module: `wb_burst_mem`

## Requirements
- R1: After reset, `ack_o` is low and `dat_o` is zero, and `ack_o` stays low until a request arrives.
- R2: A classic request (`cyc_i` and `stb_i` high) is acknowledged in the next cycle, with `dat_o` holding the word at `adr_i`. The following cycle has `ack_o` low even if the strobe stays high, so each request gets exactly one acknowledge.
- R3: `ack_o` is never high in a cycle where `stb_i` or `cyc_i` is low.
- R4: Cycle type codes are: 3'b000 classic, 3'b001 constant-address burst, 3'b010 incrementing burst and 3'b111 end of burst. Any other code is served as classic.
- R5: In an incrementing burst with burst type 2'b00 (linear) and the strobe held high, every beat after the first is acknowledged in the cycle right after the previous one. Each beat carries the word at the previous address plus one.
- R6: Burst type 2'b01, 2'b10 and 2'b11 wrap the incrementing address within aligned windows of 4, 8 and 16 words. Only the low 2, 3 or 4 address bits change.
- R7: A constant-address burst with the strobe held high is acknowledged on consecutive cycles and returns the word at the same address on every beat.
- R8: A beat presented with the end-of-burst code is acknowledged. The cycle after it has `ack_o` low, even if the strobe stays high.
- R9: If the strobe is low for one or more cycles between beats, nothing is acknowledged during the gap. The next strobe is answered one cycle later with the word at the `adr_i` then driven, even if that address differs from the predicted one. A later continuation resumes back-to-back acknowledges.
- R10: Dropping `cyc_i` between beats has the same effect as R9.
- R11: A write is committed to the word at `adr_i` in the cycle it is acknowledged, in classic and burst transfers alike. Only byte lanes whose `sel_i` bit is set are changed; bit n of `sel_i` guards `dat_i[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Beat strobe |
| we_i | input | 1 | Write enable |
| sel_i | input | DW/8 | Byte lane selects |
| adr_i | input | AW | Word address |
| dat_i | input | DW | Write data |
| cti_i | input | 3 | Cycle type code |
| bte_i | input | 2 | Burst window code |
| dat_o | output | DW | Read data |
| ack_o | output | 1 | Beat acknowledge |

## Verification
Two functions can land in the same cycle: the early acknowledge of a predicted beat and an idle gap opened by the master. In that cycle the slave already holds a fetched word and a raised acknowledge, but the strobe is low. The bench provokes this in several ways: a gap after the first beat only, a gap after every beat, a gap that drops the whole cycle, and a gap after which the master jumps to an unrelated address. It judges the result on three points: the acknowledge stays low through the gap, the resumed beat takes exactly one cycle, and the word returned belongs to the newly driven address rather than the predicted one.

// File: rtl/wb_burst_mem.sv
module wb_burst_mem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_i,
  input  logic            stb_i,
  input  logic            we_i,
  input  logic [DW/8-1:0] sel_i,
  input  logic [AW-1:0]   adr_i,
  input  logic [DW-1:0]   dat_i,
  input  logic [2:0]      cti_i,
  input  logic [1:0]      bte_i,
  output logic [DW-1:0]   dat_o,
  output logic            ack_o
);
  localparam int SW    = DW / 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] CT_CONST = 3'b001;
  localparam logic [2:0] CT_INCR  = 3'b010;
  localparam logic [2:0] CT_LAST  = 3'b111;

  logic [DW-1:0] mem [DEPTH];
  logic          ack_q;
  logic          brst_q;
  logic [AW-1:0] nxt_q;

  wire req      = cyc_i & stb_i;
  wire cti_brst = (cti_i == CT_CONST) | (cti_i == CT_INCR);
  wire fresh    = req & ~ack_q;
  wire cont     = req & ack_q & brst_q & cti_brst;
  wire [AW-1:0] rd_adr = cont ? nxt_q : adr_i;

  assign ack_o = ack_q & req;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a,
                                         input logic [2:0] c,
                                         input logic [1:0] b);
    logic [AW-1:0] inc;
    logic [AW-1:0] m;
    inc = a + 1'b1;
    case (b)
      2'b01:   m = AW'(3);
      2'b10:   m = AW'(7);
      2'b11:   m = AW'(15);
      default: m = '1;
    endcase
    if (c == CT_CONST) return a;
    return (a & ~m) | (inc & m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      brst_q <= 1'b0;
      nxt_q  <= '0;
      dat_o  <= '0;
    end else if (fresh | cont) begin
      ack_q  <= 1'b1;
      brst_q <= cti_brst;
      nxt_q  <= step(rd_adr, cti_i, bte_i);
      dat_o  <= mem[rd_adr];
    end else begin
      ack_q  <= 1'b0;
      brst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ack_o & we_i) begin
      for (int l = 0; l < SW; l++)
        if (sel_i[l]) mem[adr_i][l*8 +: 8] <= dat_i[l*8 +: 8];
    end
  end

  AST_CLASSIC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (cyc_i && stb_i && !ack_q) |=> ack_q); // R2
  AST_CLASSIC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (ack_o && cti_i != CT_CONST && cti_i != CT_INCR) |=> !ack_q); // R4
  AST_BURST_STREAM: assert property (@(posedge clk) disable iff (rst)
    (ack_o && brst_q && cti_i == CT_INCR) |=> ack_q); // R5
  AST_WRAP4_UPPER: assert property (@(posedge clk) disable iff (rst)
    (ack_o && brst_q && cti_i == CT_INCR && bte_i == 2'b01)
      |=> nxt_q[AW-1:2] == $past(nxt_q[AW-1:2])); // R6
  AST_CONST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_o && brst_q && cti_i == CT_CONST) |=> (ack_q && $stable(nxt_q))); // R7
  AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ack_o && cti_i == CT_LAST) |=> !ack_q); // R8
  AST_GAP_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (ack_q && !stb_i) |=> (!ack_q && !brst_q)); // R9
  AST_CYC_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (!cyc_i) |=> (!ack_q && !brst_q)); // R10
endmodule

// File: tb/wb_burst_mem_tb.sv
module wb_burst_mem_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [3:0]  s;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b1, 6'd3,  4'hF, 32'hDEADBEEF, 32'h0},
    '{1'b1, 6'd5,  4'hF, 32'h01234567, 32'h0},
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'hDEADBEEF},
    '{1'b1, 6'd3,  4'h5, 32'h11223344, 32'h0},
    '{1'b0, 6'd3,  4'hF, 32'h0,        32'hDE22BE44},
    '{1'b0, 6'd5,  4'hF, 32'h0,        32'h01234567},
    '{1'b1, 6'd63, 4'hF, 32'h0F0F0F0F, 32'h0},
    '{1'b1, 6'd63, 4'h2, 32'h00009900, 32'h0},
    '{1'b0, 6'd63, 4'hF, 32'h0,        32'h0F0F990F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  sel = 4'hF;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [2:0]  cti = '0;
  logic [1:0]  bte = '0;
  logic [31:0] dat_o;
  logic        ack_o;
  logic [31:0] mdl [64];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_burst_mem #(.AW(6), .DW(32)) dut_i (
    .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .sel_i(sel),
    .adr_i(adr), .dat_i(wdat), .cti_i(cti), .bte_i(bte),
    .dat_o(dat_o), .ack_o(ack_o));

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] nxt(input logic [5:0] a, input logic [2:0] c,
                                     input logic [1:0] b);
    if (c == 3'b001) return a;
    case (b)
      2'b01:   return {a[5:2], a[1:0] + 2'd1};
      2'b10:   return {a[5:3], a[2:0] + 3'd1};
      2'b11:   return {a[5:4], a[3:0] + 4'd1};
      default: return a + 6'd1;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
    logic [31:0] r = o;
    for (int l = 0; l < 4; l++) if (s[l]) r[l*8 +: 8] = n[l*8 +: 8];
    return r;
  endfunction

  task automatic classic(input logic w, input logic [5:0] a, input logic [3:0] s,
                         input logic [31:0] d, input logic [2:0] ct, input string tag,
                         output logic [31:0] rd);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d; cti = ct; bte = 2'b00;
    @(negedge clk);
    chk(ack_o == 1'b1, tag, 32'(ack_o), 32'd1);
    rd = dat_o;
    if (w) mdl[a] = merge(mdl[a], d, s);
    @(negedge clk);
    chk(ack_o == 1'b0, tag, 32'(ack_o), 32'd0);
    cyc = 0; stb = 0; we = 0; cti = 0;
  endtask

  task automatic burst(input logic w, input logic [5:0] a0, input logic [2:0] ct,
                       input logic [1:0] bt, input int n, input int gap,
                       input logic gcyc, input int jmp, input logic [3:0] s,
                       input string tag);
    logic [5:0] a = a0;
    int lat;
    logic gapped;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      gapped = (i == 0);
      if (i > 0) begin
        a = (i == 1 && jmp >= 0) ? 6'(jmp) : nxt(a, ct, bt);
        if (gap == 2 || (gap == 1 && i == 1)) begin
          stb = 0;
          if (gcyc) cyc = 0;
          #1 chk(ack_o == 1'b0, gcyc ? "R10 gap ack" : "R3 gap ack", 32'(ack_o), 32'd0);
          @(negedge clk);
          gapped = 1'b1;
        end
      end
      cyc = 1; stb = 1; we = w; adr = a; sel = s;
      wdat = {8'h5A, 8'(i), 8'h77, 2'b00, a};
      cti = (i == n - 1) ? 3'b111 : ct; bte = bt;
      lat = 0;
      #1;
      while (!ack_o && lat < 8) begin
        @(negedge clk);
        lat++;
      end
      chk(lat == (gapped ? 1 : 0), tag, 32'(lat), gapped ? 32'd1 : 32'd0);
      if (w) mdl[a] = merge(mdl[a], wdat, s);
      else   chk(dat_o == mdl[a], tag, dat_o, mdl[a]);
      @(negedge clk);
    end
    #1 chk(ack_o == 1'b0, "R8 after end", 32'(ack_o), 32'd0);
    cyc = 0; stb = 0; we = 0; cti = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ack_o == 1'b0, "R1 ack", 32'(ack_o), 32'd0);
    chk(dat_o == 32'd0, "R1 dat", dat_o, 32'd0);

    foreach (TBL[k]) begin
      classic(TBL[k].wr, TBL[k].a, TBL[k].s, TBL[k].d, 3'b000, "R2 table", rd);
      if (!TBL[k].wr) chk(rd == TBL[k].e, "R11 table read", rd, TBL[k].e);
    end

    for (int a = 0; a < 64; a++)
      classic(1'b1, 6'(a), 4'hF, {16'hC0DE, 10'd0, 6'(a)}, 3'b000, "R2 preload", rd);

    classic(1'b0, 6'd10, 4'hF, 32'h0, 3'b011, "R4 reserved code", rd);
    chk(rd == mdl[10], "R4 reserved data", rd, mdl[10]);
    classic(1'b0, 6'd11, 4'hF, 32'h0, 3'b111, "R8 lone end", rd);
    chk(rd == mdl[11], "R8 lone end data", rd, mdl[11]);

    @(negedge clk);
    cyc = 1; stb = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(ack_o == 1'b0, "R3 strobe low", 32'(ack_o), 32'd0);
    end
    cyc = 0;

    burst(1'b0, 6'd5,  3'b010, 2'b00, 4, 0, 1'b0, -1, 4'hF, "R5 linear");
    burst(1'b0, 6'd6,  3'b010, 2'b01, 4, 0, 1'b0, -1, 4'hF, "R6 wrap4");
    burst(1'b0, 6'd13, 3'b010, 2'b10, 8, 0, 1'b0, -1, 4'hF, "R6 wrap8");
    burst(1'b0, 6'd30, 3'b010, 2'b11, 4, 0, 1'b0, -1, 4'hF, "R6 wrap16");
    burst(1'b0, 6'd9,  3'b001, 2'b00, 4, 0, 1'b0, -1, 4'hF, "R7 constant");
    burst(1'b0, 6'd16, 3'b010, 2'b00, 4, 1, 1'b0, -1, 4'hF, "R9 gap first");
    burst(1'b0, 6'd21, 3'b010, 2'b01, 4, 2, 1'b0, -1, 4'hF, "R9 gap every");
    burst(1'b0, 6'd8,  3'b010, 2'b00, 4, 1, 1'b0, 40, 4'hF, "R9 jump");
    burst(1'b0, 6'd50, 3'b010, 2'b00, 4, 1, 1'b1, -1, 4'hF, "R10 cyc drop");

    burst(1'b1, 6'd22, 3'b010, 2'b01, 4, 0, 1'b0, -1, 4'h3, "R11 write burst");
    for (int a = 20; a < 24; a++) begin
      classic(1'b0, 6'(a), 4'hF, 32'h0, 3'b000, "R11 readback", rd);
      chk(rd == mdl[a], "R11 lanes", rd, mdl[a]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule